// File: doc/BRIEF.md
# Latency-Ordered Recency Placement Controller

This block runs the replacement bookkeeping for a single set of a set-associative cache whose data ways do not all answer in the same time. A static table gives every way an access class of 1, 2 or 3 cycles. The controller sorts the ways into a fixed physical ladder. Ways with a faster class come first, and within one class the lower way index comes first. The controller then keeps the lines arranged so that the line at ladder position p always has recency rank p. The youngest line sits in the quickest way and the oldest line sits in the slowest way.

A lookup arrives with a hit flag and, on a hit, the way that matched. After the access time, a one-cycle done pulse reports the access. It gives the way that was read or filled, whether the access was a hit, and the number of cycles counted from acceptance to the pulse. The accessed line then has to travel to ladder position 0. The controller issues a chain of adjacent-position swap commands on a valid/ready port, and the tag and data arrays carry them out. While that chain runs, busy is high and new lookups are refused. On a miss the victim is always the way at the last ladder position. Its access time is the external miss penalty, and the refill line then climbs the whole ladder.

Top module: `lalru_ctrl`

## Requirements
- R1: While reset is low and on the first cycle after it, the rank output holds, for each way, that way's ladder position: the count of ways with a smaller class, plus the count of ways with an equal class and a lower index. busy is 0 and req_ready is 1.
- R2: The rank output is always a permutation of 0..NWAYS-1, including in the middle of a swap chain.
- R3: Once busy falls, every way's rank equals its ladder position again. The line held at ladder position p is the one that is p-th in true recency order, where 0 is the most recent.
- R4: A lookup whose line is at ladder position r sets that way's rank to 0 on the accepting edge. Ranks below r each go up by one. The controller then issues exactly r swaps. Swap k (k = 0..r-1) pairs the ways at positions r-k and r-k-1.
- R5: On a miss, done_way is the way at ladder position NWAYS-1, done_hit is 0, done_lat equals MISS_LAT, and NWAYS-1 swaps follow.
- R6: On a hit, done is high in the c-th cycle after the accepting edge, where c is the hit way's class (1, 2 or 3), and done_lat equals c. A class-1 hit therefore completes in exactly one cycle.
- R7: A swap command that is not taken holds xchg_valid, xchg_way_a and xchg_way_b unchanged into the next cycle. At most one swap completes per cycle.
- R8: From the accepting edge until the last swap completes, busy is 1 and req_ready is 0. A request presented in that time is not taken and changes no rank or swap.
- R9: Each accepted lookup gives exactly one done pulse, one cycle wide.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lat_tbl | input | NWAYS*LAT_W | Class per way, way w at bits [w*LAT_W +: LAT_W], values 1..3 |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Controller idle, request taken on this edge |
| req_hit | input | 1 | 1 = hit in req_way, 0 = miss |
| req_way | input | $clog2(NWAYS) | Way that hit (ignored on miss) |
| done | output | 1 | One-cycle completion pulse |
| done_hit | output | 1 | Completed access was a hit |
| done_way | output | $clog2(NWAYS) | Way read (hit) or victim filled (miss) |
| done_lat | output | CNT_W | Counted access cycles |
| xchg_valid | output | 1 | Swap command pending |
| xchg_ready | input | 1 | Arrays accept the swap this edge |
| xchg_way_a | output | $clog2(NWAYS) | Slower way of the pair |
| xchg_way_b | output | $clog2(NWAYS) | Faster way of the pair |
| busy | output | 1 | Access or swap chain in progress |
| ranks | output | NWAYS*$clog2(NWAYS) | Recency rank of each way, way w at bits [w*RW +: RW] |

## Verification
The assertions assume that lat_tbl holds still between resets and that every class value lies in 1..3. They also assume that the array side raises xchg_ready only on its own timing, with no dependence on the other outputs in the same cycle. The bench sets a new table only while reset is low, and it draws classes only from 1..3. It drives xchg_ready at random from the falling edge, stalling about a third of the swap cycles. On a miss it never sends a hit way. Requests raised during busy are deliberate probes, and the bench lowers them again as soon as it sees the controller idle.

// File: rtl/lalru_pkg.sv
package lalru_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACCESS = 2'd1,
      ST_SWAP   = 2'd2
   } seq_state_t;
endpackage

// File: rtl/lalru_sorter.sv
// Ladder order of the ways: class ascending, lower index first within a class.
module lalru_sorter #(
   parameter int NWAYS = 8,
   parameter int LAT_W = 2,
   localparam int RW   = $clog2(NWAYS)
) (
   input  logic [NWAYS*LAT_W-1:0] lat_tbl,
   output logic [NWAYS*RW-1:0]    pos_flat,
   output logic [NWAYS*RW-1:0]    wop_flat
);
   logic [LAT_W-1:0] cls [NWAYS];
   logic [RW-1:0]    pos [NWAYS];
   logic [RW-1:0]    wop [NWAYS];

   for (genvar g = 0; g < NWAYS; g++) begin : g_unpack
      assign cls[g] = lat_tbl[g*LAT_W +: LAT_W];
      assign pos_flat[g*RW +: RW] = pos[g];
      assign wop_flat[g*RW +: RW] = wop[g];
   end

   always_comb begin
      for (int w = 0; w < NWAYS; w++) begin
         int c;
         c = 0;
         for (int v = 0; v < NWAYS; v++) begin
            if ((cls[v] < cls[w]) || ((cls[v] == cls[w]) && (v < w))) c++;
         end
         pos[w] = RW'(c);
      end
   end

   always_comb begin
      for (int p = 0; p < NWAYS; p++) begin
         wop[p] = '0;
         for (int w = 0; w < NWAYS; w++) begin
            if (pos[w] == RW'(p)) wop[p] = RW'(w);
         end
      end
   end
endmodule

// File: rtl/lalru_ranks.sv
// Recency rank store: promotion on accept, pairwise exchange on each swap.
module lalru_ranks #(
   parameter int NWAYS = 8,
   localparam int RW   = $clog2(NWAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NWAYS*RW-1:0] init_flat,
   input  logic                upd_en,
   input  logic [RW-1:0]       upd_r,
   input  logic                swp_en,
   input  logic [RW-1:0]       swp_a,
   input  logic [RW-1:0]       swp_b,
   output logic [NWAYS*RW-1:0] rank_flat
);
   logic [RW-1:0]    rk [NWAYS];
   logic [NWAYS-1:0] seen;

   for (genvar g = 0; g < NWAYS; g++) begin : g_out
      assign rank_flat[g*RW +: RW] = rk[g];
   end

   always_ff @(posedge clk) begin
      for (int w = 0; w < NWAYS; w++) begin
         if (!rst_n) begin
            rk[w] <= init_flat[w*RW +: RW];
         end else if (upd_en) begin
            if (rk[w] == upd_r)     rk[w] <= '0;
            else if (rk[w] < upd_r) rk[w] <= rk[w] + 1'b1;
         end else if (swp_en) begin
            if (RW'(w) == swp_a)      rk[w] <= rk[swp_b];
            else if (RW'(w) == swp_b) rk[w] <= rk[swp_a];
         end
      end
   end

   always_comb begin
      seen = '0;
      for (int w = 0; w < NWAYS; w++) seen[rk[w]] = 1'b1;
   end

   a_r2_rank_perm: assert property (@(posedge clk) disable iff (!rst_n)
      &seen);

   a_r4_promote_front: assert property (@(posedge clk) disable iff (!rst_n)
      upd_en |=> ($countones(seen) == NWAYS));
endmodule

// File: rtl/lalru_seq.sv
// Access timer and swap-chain sequencer.
module lalru_seq
   import lalru_pkg::*;
#(
   parameter int NWAYS    = 8,
   parameter int LAT_W    = 2,
   parameter int CNT_W    = 4,
   parameter int MISS_LAT = 12,
   localparam int RW      = $clog2(NWAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_hit,
   input  logic [RW-1:0]       req_way,
   input  logic [RW-1:0]       hit_rank,
   input  logic [LAT_W-1:0]    hit_lat,
   input  logic [NWAYS*RW-1:0] wop_flat,
   input  logic                xchg_ready,
   output logic                req_ready,
   output logic                busy,
   output logic                done,
   output logic                done_hit,
   output logic [RW-1:0]       done_way,
   output logic [CNT_W-1:0]    done_lat,
   output logic                xchg_valid,
   output logic [RW-1:0]       xchg_a,
   output logic [RW-1:0]       xchg_b,
   output logic                upd_en,
   output logic [RW-1:0]       upd_r,
   output logic                swp_en
);
   seq_state_t       st;
   logic [CNT_W-1:0] cnt, tgt;
   logic [RW-1:0]    cur, cur_m1, victim;
   logic             accept;

   assign victim  = wop_flat[(NWAYS-1)*RW +: RW];
   assign cur_m1  = cur - 1'b1;
   assign accept  = req_valid && (st == ST_IDLE);
   assign upd_en  = accept;
   assign upd_r   = req_hit ? hit_rank : RW'(NWAYS-1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         tgt      <= '0;
         cur      <= '0;
         done_hit <= 1'b0;
         done_way <= '0;
      end else begin
         case (st)
            ST_IDLE: if (accept) begin
               st       <= ST_ACCESS;
               cnt      <= CNT_W'(1);
               done_hit <= req_hit;
               done_way <= req_hit ? req_way : victim;
               cur      <= upd_r;
               if (!req_hit)          tgt <= CNT_W'(MISS_LAT);
               else if (hit_lat == 0) tgt <= CNT_W'(1);
               else                   tgt <= CNT_W'(hit_lat);
            end
            ST_ACCESS: begin
               if (cnt == tgt) st <= (cur == '0) ? ST_IDLE : ST_SWAP;
               else            cnt <= cnt + 1'b1;
            end
            ST_SWAP: if (xchg_ready) begin
               cur <= cur_m1;
               if (cur == RW'(1)) st <= ST_IDLE;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy       = (st != ST_IDLE);
   assign req_ready  = (st == ST_IDLE);
   assign done       = (st == ST_ACCESS) && (cnt == tgt);
   assign done_lat   = cnt;
   assign xchg_valid = (st == ST_SWAP);
   assign xchg_a     = wop_flat[cur*RW +: RW];
   assign xchg_b     = wop_flat[cur_m1*RW +: RW];
   assign swp_en     = xchg_valid && xchg_ready;

   a_r7_hold_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (xchg_valid && !xchg_ready) |=> (xchg_valid && $stable(xchg_a) && $stable(xchg_b)));

   a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r5_miss_time: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !done_hit) |-> (done_lat == CNT_W'(MISS_LAT)));

   a_r8_no_take_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && req_valid) |=> (busy || $past(xchg_valid) || $past(done)));
endmodule

// File: rtl/lalru_ctrl.sv
module lalru_ctrl #(
   parameter int NWAYS    = 8,
   parameter int LAT_W    = 2,
   parameter int MISS_LAT = 12,
   localparam int RW      = $clog2(NWAYS),
   localparam int LMAX    = (MISS_LAT > 3) ? MISS_LAT : 3,
   localparam int CNT_W   = $clog2(LMAX + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NWAYS*LAT_W-1:0] lat_tbl,
   input  logic                   req_valid,
   output logic                   req_ready,
   input  logic                   req_hit,
   input  logic [RW-1:0]          req_way,
   output logic                   done,
   output logic                   done_hit,
   output logic [RW-1:0]          done_way,
   output logic [CNT_W-1:0]       done_lat,
   output logic                   xchg_valid,
   input  logic                   xchg_ready,
   output logic [RW-1:0]          xchg_way_a,
   output logic [RW-1:0]          xchg_way_b,
   output logic                   busy,
   output logic [NWAYS*RW-1:0]    ranks
);
   initial begin
      assert (NWAYS >= 2 && (1 << RW) == NWAYS) else $error("NWAYS must be a power of two >= 2");
      assert (LAT_W >= 2) else $error("LAT_W must hold classes 1..3");
      assert (MISS_LAT >= 1) else $error("MISS_LAT must be positive");
   end

   logic [NWAYS*RW-1:0] pos_flat, wop_flat;
   logic                upd_en, swp_en;
   logic [RW-1:0]       upd_r, hit_rank;
   logic [LAT_W-1:0]    hit_lat;
   logic                settled;

   assign hit_rank = ranks[req_way*RW +: RW];
   assign hit_lat  = lat_tbl[req_way*LAT_W +: LAT_W];

   lalru_sorter #(.NWAYS(NWAYS), .LAT_W(LAT_W)) u_sort (
      .lat_tbl (lat_tbl),
      .pos_flat(pos_flat),
      .wop_flat(wop_flat)
   );

   lalru_ranks #(.NWAYS(NWAYS)) u_ranks (
      .clk      (clk),
      .rst_n    (rst_n),
      .init_flat(pos_flat),
      .upd_en   (upd_en),
      .upd_r    (upd_r),
      .swp_en   (swp_en),
      .swp_a    (xchg_way_a),
      .swp_b    (xchg_way_b),
      .rank_flat(ranks)
   );

   lalru_seq #(.NWAYS(NWAYS), .LAT_W(LAT_W), .CNT_W(CNT_W), .MISS_LAT(MISS_LAT)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_hit   (req_hit),
      .req_way   (req_way),
      .hit_rank  (hit_rank),
      .hit_lat   (hit_lat),
      .wop_flat  (wop_flat),
      .xchg_ready(xchg_ready),
      .req_ready (req_ready),
      .busy      (busy),
      .done      (done),
      .done_hit  (done_hit),
      .done_way  (done_way),
      .done_lat  (done_lat),
      .xchg_valid(xchg_valid),
      .xchg_a    (xchg_way_a),
      .xchg_b    (xchg_way_b),
      .upd_en    (upd_en),
      .upd_r     (upd_r),
      .swp_en    (swp_en)
   );

   always_comb begin
      settled = 1'b1;
      for (int w = 0; w < NWAYS; w++)
         if (ranks[w*RW +: RW] != pos_flat[w*RW +: RW]) settled = 1'b0;
   end

   a_r3_settled_order: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> settled);

   a_r1_idle_order: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> settled);

   a_r6_hit_time: assert property (@(posedge clk) disable iff (!rst_n)
      (done && done_hit && (lat_tbl[done_way*LAT_W +: LAT_W] != 0))
         |-> (done_lat == CNT_W'(lat_tbl[done_way*LAT_W +: LAT_W])));

   a_r7_adjacent: assert property (@(posedge clk) disable iff (!rst_n)
      xchg_valid |-> (pos_flat[xchg_way_a*RW +: RW] == pos_flat[xchg_way_b*RW +: RW] + 1'b1));
endmodule

// File: tb/sim_lalru_ctrl.sv
module sim_lalru_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NW   = 8;
   localparam int RW   = 3;
   localparam int MISS = 12;
   localparam int CW   = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NW*2-1:0]   lat_tbl = 16'h5555;
   logic              req_valid = 1'b0, req_hit = 1'b0, xchg_ready = 1'b0;
   logic [RW-1:0]     req_way = '0;
   logic              req_ready, done, done_hit, xchg_valid, busy;
   logic [RW-1:0]     done_way, xchg_way_a, xchg_way_b;
   logic [CW-1:0]     done_lat;
   logic [NW*RW-1:0]  ranks;

   int n_chk = 0, n_fail = 0;
   int tbl [NW];
   int bpos [NW];
   int bwop [NW];
   int lines [NW];
   int order [NW];
   int next_id = 100;

   always #(CLK_PERIOD/2) clk = ~clk;

   lalru_ctrl #(.NWAYS(NW), .LAT_W(2), .MISS_LAT(MISS)) u0 (
      .clk(clk), .rst_n(rst_n), .lat_tbl(lat_tbl),
      .req_valid(req_valid), .req_ready(req_ready), .req_hit(req_hit), .req_way(req_way),
      .done(done), .done_hit(done_hit), .done_way(done_way), .done_lat(done_lat),
      .xchg_valid(xchg_valid), .xchg_ready(xchg_ready),
      .xchg_way_a(xchg_way_a), .xchg_way_b(xchg_way_b),
      .busy(busy), .ranks(ranks)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int rk(input int w);
      return int'(ranks[w*RW +: RW]);
   endfunction

   function automatic bit is_perm();
      bit [NW-1:0] s = '0;
      for (int w = 0; w < NW; w++) s[ranks[w*RW +: RW]] = 1'b1;
      return &s;
   endfunction

   task automatic start(input logic [15:0] t);
      @(negedge clk);
      rst_n = 1'b0;
      lat_tbl = t;
      for (int w = 0; w < NW; w++) tbl[w] = int'(t[w*2 +: 2]);
      for (int w = 0; w < NW; w++) begin
         int c = 0;
         for (int v = 0; v < NW; v++)
            if (tbl[v] < tbl[w] || (tbl[v] == tbl[w] && v < w)) c++;
         bpos[w] = c;
         bwop[c] = w;
      end
      repeat (3) @(negedge clk);
      for (int w = 0; w < NW; w++) chk(rk(w) == bpos[w], "R1 rank in reset", rk(w), bpos[w]);
      rst_n = 1'b1;
      @(negedge clk);
      for (int w = 0; w < NW; w++) chk(rk(w) == bpos[w], "R1 rank after reset", rk(w), bpos[w]);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
      for (int p = 0; p < NW; p++) begin
         lines[bwop[p]] = next_id;
         order[p] = next_id;
         next_id++;
      end
   endtask

   // r in 0..NW-1 is a hit at that ladder position; r == NW is a miss
   task automatic do_op(input int r_in);
      bit hit = (r_in < NW);
      int r = hit ? r_in : NW-1;
      int exp_way = hit ? bwop[r] : bwop[NW-1];
      int exp_lat = hit ? tbl[bwop[r]] : MISS;
      int id = order[r];
      int n = 1, nx = 0, ndone = 0;
      int nid = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_hit = hit;
      req_way = hit ? RW'(bwop[r]) : RW'($urandom_range(0, NW-1));
      @(negedge clk);
      req_valid = 1'b0;
      chk(rk(exp_way) == 0, "R4 promoted rank", rk(exp_way), 0);
      for (int guard = 0; guard < 400; guard++) begin
         if (!busy) begin
            req_valid = 1'b0;
            break;
         end
         chk(is_perm(), "R2 rank permutation", 0, 1);
         chk(req_ready == 1'b0, "R8 ready low while busy", req_ready, 0);
         if (done) begin
            ndone++;
            chk(n == exp_lat, hit ? "R6 hit latency" : "R5 miss latency", n, exp_lat);
            chk(int'(done_lat) == exp_lat, hit ? "R6 done_lat" : "R5 done_lat", done_lat, exp_lat);
            chk(int'(done_way) == exp_way, hit ? "R6 done_way" : "R5 victim way", done_way, exp_way);
            chk(done_hit == hit, "R9 done_hit", done_hit, hit);
            if (!hit) begin
               nid = next_id++;
               lines[exp_way] = nid;
            end
         end
         req_valid = ($urandom_range(0, 3) == 0);
         req_hit = 1'b1;
         req_way = RW'($urandom_range(0, NW-1));
         if (xchg_valid) begin
            chk(int'(xchg_way_a) == bwop[r-nx], "R4 swap slower way", xchg_way_a, bwop[r-nx]);
            chk(int'(xchg_way_b) == bwop[r-nx-1], "R4 swap faster way", xchg_way_b, bwop[r-nx-1]);
            xchg_ready = ($urandom_range(0, 2) != 0);
            if (xchg_ready) begin
               int tmp = lines[xchg_way_a];
               lines[xchg_way_a] = lines[xchg_way_b];
               lines[xchg_way_b] = tmp;
               nx++;
            end
         end else begin
            xchg_ready = ($urandom_range(0, 1) == 0);
         end
         @(negedge clk);
         n++;
      end
      xchg_ready = 1'b0;
      chk(ndone == 1, "R9 one done pulse", ndone, 1);
      chk(nx == r, hit ? "R4 swap count" : "R5 swap count", nx, r);
      if (hit) begin
         for (int p = r; p > 0; p--) order[p] = order[p-1];
         order[0] = id;
      end else begin
         for (int p = NW-1; p > 0; p--) order[p] = order[p-1];
         order[0] = nid;
      end
      for (int p = 0; p < NW; p++)
         chk(lines[bwop[p]] == order[p], "R3 line placement", lines[bwop[p]], order[p]);
      for (int w = 0; w < NW; w++)
         chk(rk(w) == bpos[w], "R3 rank settled", rk(w), bpos[w]);
      // R8: probe requests during busy must not have started a new access
      @(negedge clk);
      chk(busy == 1'b0, "R8 no stray accept", busy, 0);
   endtask

   task automatic sweep(input logic [15:0] t);
      start(t);
      for (int r = 0; r <= NW; r++) do_op(r);
      for (int r = NW; r >= 0; r--) do_op(r);
      for (int k = 0; k < 25; k++) do_op($urandom_range(0, NW));
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      sweep(16'h5555);
      sweep(16'h7967);
      sweep(16'hFFFF);
      sweep(16'h67DA);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule